// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps host-side outbound memory addresses onto a 64-bit bus address space through a table of equal-sized windows. The host region starts at a fixed base. Software chooses one window size for the whole table as a power-of-two number of megabytes. It then loads each window with a 64-bit target made of a low and a high word. The low word also carries a per-window enable in its least significant bit. A global enable bit in a command register gates every translation.

Each lookup presents a host address. The window is selected from the address bits above the window size. One cycle later the block returns a hit flag and the translated address. A lookup misses when translation is off, when the selected window is disabled, or when the address falls outside the table. All registers sit behind a plain 32-bit write/read port with registered read data.

Top module: `oat_xlate`

## Requirements
- R1: After reset every register reads as zero, translation is off and no lookup response is signalled.
- R2: Register map, all word aligned: command at 0x004 (32 bits, read back in full), size index at 0x030 (bits 2:0 stored, upper bits read 0), window n low word at 0x200+8n and high word at 0x204+8n. Any other or unaligned address reads 0 and ignores writes. Read data appears the cycle after the read strobe and is 0 in cycles that follow no read.
- R3: rsp_valid is high exactly in the cycle after lk_valid was high.
- R4: The window size is 2^(size index) MB. The window number is (lk_addr - base) >> (20 + size index).
- R5: On a hit, rsp_addr equals {high word, low word} with the bits below the window size cleared, plus lk_addr's bits below the window size.
- R6: When command bit 1 is 0, every lookup misses.
- R7: A window whose low word has bit 0 at 0 always misses.
- R8: An address below the base, or one whose window number is 32 or more, misses.
- R9: On a miss, rsp_hit is 0 and rsp_addr is 0.
- R10: A register write and a lookup in the same cycle: the lookup uses the values held before the write. The new values apply from the next cycle's lookup.
- R11: Command bits other than bit 1 have no effect on translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Host address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_addr | output | 64 | Translated bus address, 0 on a miss |

## Verification
A register write and a lookup can land on the same clock edge. This matters most when the write changes the size index, a window's low word, or the global enable. The bench provokes it by driving both in one cycle. It then repeats the identical lookup in the next cycle. A behavioural model scores every cycle and expects the first lookup to use the old register values and the second to use the new ones.

// File: rtl/oat_pkg.sv
package oat_pkg;

    typedef logic [31:0] word_t;

    localparam logic [11:0] CMD_OFS    = 12'h004;
    localparam logic [11:0] SIZE_OFS   = 12'h030;
    localparam logic [11:0] WIN_OFS    = 12'h200;
    localparam int          XLATE_BIT  = 1;
    localparam int          MB_SHIFT   = 20;
    localparam int          SIZE_W     = 3;
    localparam int          BUS_AW     = 64;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [BUS_AW-1:0] addr;
    } rsp_t;

endpackage

// File: rtl/oat_regfile.sv
module oat_regfile
    import oat_pkg::*;
#(
    parameter int NUM_WIN = 32,
    parameter int REG_AW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  word_t             reg_wdata,
    output word_t             reg_rdata,
    output logic              xlate_en,
    output logic [SIZE_W-1:0] size_idx,
    output word_t             win_lo [NUM_WIN],
    output word_t             win_hi [NUM_WIN]
);

    localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int WIN_END = int'(WIN_OFS) + NUM_WIN * 8;

    typedef struct packed {
        word_t             cmd;
        logic [SIZE_W-1:0] size;
        word_t             rdata;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    word_t lo_d [NUM_WIN];
    word_t lo_q [NUM_WIN];
    word_t hi_d [NUM_WIN];
    word_t hi_q [NUM_WIN];

    logic             is_cmd, is_size, is_win, is_hi;
    logic [WIN_W:0]   rel_w;
    logic [WIN_W-1:0] win_n;
    word_t            rd_val;

    // address decode shared by the read and write paths
    always_comb begin
        is_cmd  = (reg_addr == REG_AW'(CMD_OFS));
        is_size = (reg_addr == REG_AW'(SIZE_OFS));
        is_win  = (int'(reg_addr) >= int'(WIN_OFS)) && (int'(reg_addr) < WIN_END)
                  && (reg_addr[1:0] == 2'b00);
        rel_w   = (WIN_W+1)'((reg_addr - REG_AW'(WIN_OFS)) >> 2);
        win_n   = rel_w[WIN_W:1];
        is_hi   = rel_w[0];
    end

    always_comb begin
        rd_val = '0;
        if (is_cmd) begin
            rd_val = ctl_q.cmd;
        end else if (is_size) begin
            rd_val = {{(32-SIZE_W){1'b0}}, ctl_q.size};
        end else if (is_win) begin
            rd_val = is_hi ? hi_q[win_n] : lo_q[win_n];
        end
    end

    always_comb begin
        ctl_d       = ctl_q;
        lo_d        = lo_q;
        hi_d        = hi_q;
        ctl_d.rdata = reg_rd ? rd_val : '0;
        if (reg_wr) begin
            if (is_cmd) begin
                ctl_d.cmd = reg_wdata;
            end else if (is_size) begin
                ctl_d.size = reg_wdata[SIZE_W-1:0];
            end else if (is_win) begin
                if (is_hi) begin
                    hi_d[win_n] = reg_wdata;
                end else begin
                    lo_d[win_n] = reg_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < NUM_WIN; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
        end else begin
            ctl_q <= ctl_d;
            lo_q  <= lo_d;
            hi_q  <= hi_d;
        end
    end

    assign reg_rdata = ctl_q.rdata;
    assign xlate_en  = ctl_q.cmd[XLATE_BIT];
    assign size_idx  = ctl_q.size;
    assign win_lo    = lo_q;
    assign win_hi    = hi_q;

endmodule

// File: rtl/oat_lookup.sv
module oat_lookup
    import oat_pkg::*;
#(
    parameter int              NUM_WIN     = 32,
    parameter int              HOST_AW     = 32,
    parameter logic [HOST_AW-1:0] REGION_BASE = 32'h4000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xlate_en,
    input  logic [SIZE_W-1:0]  size_idx,
    input  word_t              win_lo [NUM_WIN],
    input  word_t              win_hi [NUM_WIN],
    input  logic               lk_valid,
    input  logic [HOST_AW-1:0] lk_addr,
    output rsp_t               rsp
);

    localparam int                 WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam logic [HOST_AW-1:0] NWIN_H = HOST_AW'(NUM_WIN);

    rsp_t               rsp_d, rsp_q;
    logic [HOST_AW-1:0] ofs, wfull;
    logic [5:0]         shamt;
    logic               in_rng;
    logic [WIN_W-1:0]   widx;
    word_t              sel_lo, sel_hi;
    logic [BUS_AW-1:0]  mask, xl;

    always_comb begin
        ofs    = lk_addr - REGION_BASE;
        shamt  = 6'(MB_SHIFT) + 6'(size_idx);
        wfull  = ofs >> shamt;
        in_rng = (lk_addr >= REGION_BASE) && (wfull < NWIN_H);
        widx   = in_rng ? wfull[WIN_W-1:0] : '0;
        sel_lo = win_lo[widx];
        sel_hi = win_hi[widx];
        mask   = (BUS_AW'(1) << shamt) - BUS_AW'(1);
        xl     = ({sel_hi, sel_lo} & ~mask)
               + ({{(BUS_AW-HOST_AW){1'b0}}, lk_addr} & mask);

        rsp_d       = '0;
        rsp_d.valid = lk_valid;
        rsp_d.hit   = lk_valid && xlate_en && in_rng && sel_lo[0];
        rsp_d.addr  = rsp_d.hit ? xl : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp = rsp_q;

endmodule

// File: rtl/oat_xlate.sv
module oat_xlate
    import oat_pkg::*;
#(
    parameter int                 NUM_WIN     = 32,
    parameter int                 HOST_AW     = 32,
    parameter int                 REG_AW      = 12,
    parameter logic [HOST_AW-1:0] REGION_BASE = 32'h4000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               lk_valid,
    input  logic [HOST_AW-1:0] lk_addr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [63:0]        rsp_addr
);

    logic              xlate_en;
    logic [SIZE_W-1:0] size_idx;
    word_t             win_lo [NUM_WIN];
    word_t             win_hi [NUM_WIN];
    rsp_t              rsp;

    oat_regfile #(
        .NUM_WIN (NUM_WIN),
        .REG_AW  (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .xlate_en  (xlate_en),
        .size_idx  (size_idx),
        .win_lo    (win_lo),
        .win_hi    (win_hi)
    );

    oat_lookup #(
        .NUM_WIN     (NUM_WIN),
        .HOST_AW     (HOST_AW),
        .REGION_BASE (REGION_BASE)
    ) u_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .xlate_en (xlate_en),
        .size_idx (size_idx),
        .win_lo   (win_lo),
        .win_hi   (win_hi),
        .lk_valid (lk_valid),
        .lk_addr  (lk_addr),
        .rsp      (rsp)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_hit   = rsp.hit;
    assign rsp_addr  = rsp.addr;

endmodule

// File: rtl/oat_xlate_chk.sv
module oat_xlate_chk
    import oat_pkg::*;
#(
    parameter int                 HOST_AW     = 32,
    parameter int                 REG_AW      = 12,
    parameter logic [HOST_AW-1:0] REGION_BASE = 32'h4000_0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [REG_AW-1:0]  reg_addr,
    input logic               cmd_bit,
    input logic               lk_valid,
    input logic [HOST_AW-1:0] lk_addr,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [63:0]        rsp_addr
);

    // independent shadow of the global enable, taken from the write port
    logic en_shadow_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_shadow_q <= 1'b0;
        end else if (reg_wr && reg_addr == REG_AW'(CMD_OFS)) begin
            en_shadow_q <= cmd_bit;
        end
    end

    // R3
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R3
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R9
    miss_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == 64'd0));

    // R6
    xlate_off_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !en_shadow_q) |=> !rsp_hit);

    // R8
    below_base_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (lk_addr < REGION_BASE)) |=> !rsp_hit);

    // R5
    low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || (rsp_addr[MB_SHIFT-1:0] == $past(lk_addr[MB_SHIFT-1:0]))));

    // R9
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

endmodule

bind oat_xlate oat_xlate_chk #(
    .HOST_AW     (HOST_AW),
    .REG_AW      (REG_AW),
    .REGION_BASE (REGION_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .cmd_bit   (reg_wdata[1]),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_addr  (rsp_addr)
);

// File: tb/oat_xlate_tb.sv
`timescale 1ns/1ps
module oat_xlate_tb;

    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam int          MB   = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [63:0] rsp_addr;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    string tag_q = "R1";
    bit scoring = 1'b0;
    bit done = 1'b0;

    oat_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    logic [31:0] m_cmd;
    logic [2:0]  m_size;
    logic [31:0] m_lo [32];
    logic [31:0] m_hi [32];
    bit          e_valid, e_hit;
    logic [63:0] e_addr;
    logic [31:0] e_rdata;

    function automatic logic [31:0] m_read(input logic [11:0] a);
        if (a == 12'h004) return m_cmd;
        if (a == 12'h030) return {29'd0, m_size};
        if (a >= 12'h200 && a < 12'h300 && a[1:0] == 2'b00)
            return a[2] ? m_hi[(a - 12'h200) / 8] : m_lo[(a - 12'h200) / 8];
        return 32'd0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cmd = 0; m_size = 0;
            for (int i = 0; i < 32; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
            e_valid = 0; e_hit = 0; e_addr = 0; e_rdata = 0;
        end else begin
            longint unsigned ofs, w, msk;
            int sh;
            tag_q   = cur_req;
            e_valid = lk_valid;
            e_hit   = 0;
            e_addr  = 0;
            sh = 20 + m_size;
            if (lk_valid && m_cmd[1] && lk_addr >= BASE) begin
                ofs = longint'(lk_addr) - longint'(BASE);
                w   = ofs >> sh;
                if (w < 32 && m_lo[w][0]) begin
                    msk    = (64'd1 << sh) - 1;
                    e_addr = ({m_hi[w], m_lo[w]} & ~msk) + (longint'(lk_addr) & msk);
                    e_hit  = 1;
                end
            end
            e_rdata = reg_rd ? m_read(reg_addr) : 32'd0;
            if (reg_wr) begin
                if (reg_addr == 12'h004) m_cmd = reg_wdata;
                else if (reg_addr == 12'h030) m_size = reg_wdata[2:0];
                else if (reg_addr >= 12'h200 && reg_addr < 12'h300 && reg_addr[1:0] == 2'b00) begin
                    if (reg_addr[2]) m_hi[(reg_addr - 12'h200) / 8] = reg_wdata;
                    else             m_lo[(reg_addr - 12'h200) / 8] = reg_wdata;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            chk(rsp_valid == 0 && rsp_hit == 0 && rsp_addr == 0 && reg_rdata == 0,
                "R1", "outputs in reset", {rsp_valid, rsp_hit, rsp_addr[31:0], reg_rdata[29:0]}, 0);
        end else if (scoring) begin
            chk(rsp_valid == e_valid, tag_q, "rsp_valid", 64'(rsp_valid), 64'(e_valid));
            chk(rsp_hit == e_hit, tag_q, "rsp_hit", 64'(rsp_hit), 64'(e_hit));
            chk(rsp_addr == e_addr, tag_q, "rsp_addr", rsp_addr, e_addr);
            chk(reg_rdata == e_rdata, tag_q, "reg_rdata", 64'(reg_rdata), 64'(e_rdata));
        end
    end

    task automatic step(input string req, input bit wr, input bit rd, input logic [11:0] a,
                        input logic [31:0] wd, input bit lv, input logic [31:0] la);
        @(negedge clk);
        cur_req = req; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        lk_valid = lv; lk_addr = la;
    endtask

    task automatic wr(input string req, input logic [11:0] a, input logic [31:0] d);
        step(req, 1, 0, a, d, 0, 0);
    endtask
    task automatic rd(input string req, input logic [11:0] a);
        step(req, 0, 1, a, 0, 0, 0);
    endtask
    task automatic lk(input string req, input logic [31:0] a);
        step(req, 0, 0, 0, 0, 1, a);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        scoring = 1'b1;
        // R1 reset values
        rd("R1", 12'h004); rd("R1", 12'h030); rd("R1", 12'h200); rd("R1", 12'h2FC);
        lk("R1", BASE);
        // R11: every command bit except bit 1 set, translation stays off (R6)
        wr("R11", 12'h004, 32'hFFFF_FFFD);
        wr("R11", 12'h200, 32'h8000_0001); wr("R11", 12'h204, 32'h0000_0001);
        lk("R11", BASE + 32'h123); lk("R6", BASE + 32'h0F_0000);
        rd("R2", 12'h004);
        // enable with extra bits
        wr("R11", 12'h004, 32'h0000_00A2);
        lk("R5", BASE + 32'h1_2345);
        // window 1, size 1 MB
        wr("R4", 12'h208, 32'h9010_0001); wr("R4", 12'h20C, 32'h0000_DEAD);
        lk("R4", BASE + 32'h1F_FFFF); lk("R4", BASE + 32'h10_0000);
        // R7 disabled window 5
        wr("R7", 12'h228, 32'h7000_0000); wr("R7", 12'h22C, 32'h0000_0077);
        lk("R7", BASE + 5 * MB + 32'h10);
        // R8 last window, past the table, below the base
        wr("R8", 12'h2F8, 32'hA000_0001);
        lk("R8", BASE + 31 * MB + 7); lk("R8", BASE + 32 * MB); lk("R8", BASE - 1);
        // R2 readback and size field width
        rd("R2", 12'h208); rd("R2", 12'h20C); rd("R2", 12'h2F8);
        wr("R2", 12'h030, 32'hFFFF_FFFB); rd("R2", 12'h030);
        // R4 with 8 MB windows
        lk("R4", BASE + 8 * MB + 32'h12_3456); lk("R8", BASE + 256 * MB);
        // R10 size change and lookup in the same cycle, then repeated
        step("R10", 1, 0, 12'h030, 32'h0, 1, BASE + 8 * MB + 32'h4);
        lk("R10", BASE + 8 * MB + 32'h4);
        // R10 window disable and lookup in the same cycle
        step("R10", 1, 0, 12'h200, 32'h8000_0000, 1, BASE + 32'h55);
        lk("R10", BASE + 32'h55);
        // R10 global enable dropped in the same cycle
        step("R10", 1, 0, 12'h004, 32'h0, 1, BASE + MB + 32'h9);
        lk("R6", BASE + MB + 32'h9);
        wr("R6", 12'h004, 32'h2);
        // R2 unmapped and unaligned accesses ignored
        wr("R2", 12'h100, 32'hFFFF_FFFF); rd("R2", 12'h100);
        wr("R2", 12'h20A, 32'h1234_5678); rd("R2", 12'h208); rd("R2", 12'h300);
        // largest size, window 16
        wr("R4", 12'h030, 32'h7); wr("R4", 12'h280, 32'h0000_0001); wr("R4", 12'h284, 32'h55);
        lk("R4", BASE + 32'h8000_0005); lk("R8", 32'h0000_1000);
        // R3 back-to-back and idle gaps with mixed sizes
        for (int i = 0; i < 60; i++) begin
            if (i % 15 == 0) wr("R4", 12'h030, 32'(i / 15));
            else if (i % 7 == 0) step("R3", 0, 0, 0, 0, 0, 0);
            else lk("R3", BASE + (32'($urandom) & 32'h3FFF_FFFF));
        end
        step("R3", 0, 0, 0, 0, 0, 0);
        step("R3", 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule